// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Lane

This block is a single processing lane of a small SIMD multiply-accumulate engine. In each clock cycle it may accept one pair of signed 8-bit operands, which the surrounding core extracts from packed 32-bit vector words. It multiplies the pair and adds the sign-extended product into a private 32-bit accumulator. When the running total would go past the signed 32-bit range, the accumulator clamps at the limit instead of wrapping round.

The datapath has two register stages. The first stage captures the product in a register. The second stage is the accumulator feedback loop, which adds that registered product. The multiplier and the accumulator adder therefore never share one combinational path. A synchronous clear empties both stages. Operand buffering, the handshake and output-valid timing belong to the enclosing core. The lane exposes only the live accumulator value.

Top module: `sat_mac_lane`

## Requirements
- R1: While `rst_n` is low at a rising edge, and from the first edge after reset onward until a product is added, `acc_out` is 0 whatever `in_valid`, `op_a` and `op_b` carry.
- R2: A pair presented with `in_valid` high, in the cycle before rising edge k, is added into `acc_out` at rising edge k+1. It is visible after that edge and not before.
- R3: `op_a` and `op_b` are two's-complement 8-bit values. Their 16-bit product is sign-extended to 32 bits before it is added. For example, 0x80 times 0x80 adds +16384 and 0x80 times 0x7F adds -16256.
- R4: A cycle with `in_valid` low contributes nothing, and the values on `op_a` and `op_b` in that cycle have no effect on `acc_out`.
- R5: If a sum exceeds +2^31-1, `acc_out` becomes 32'h7FFFFFFF. A sum equal to or below that value is stored exactly.
- R6: If a sum falls below -2^31, `acc_out` becomes 32'h80000000. A sum equal to or above that value is stored exactly.
- R7: An accumulator at a limit stays there while further products of the same sign arrive. It moves off the limit by exactly the product when a product of the opposite sign arrives.
- R8: `clr` high at a rising edge (with `rst_n` high) sets `acc_out` to 0 at that edge. It also discards both the pair presented in that cycle and any product already registered, so `acc_out` is still 0 one edge later unless new pairs arrive.
- R9: The accumulator width is the parameter `ACC_W` (default 32). The limits are 2^(ACC_W-1)-1 and -2^(ACC_W-1), and the rules in R5 to R7 apply to them at any width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of product stage and accumulator; wins over accumulation |
| in_valid | input | 1 | Operand pair on `op_a`/`op_b` is to be accumulated |
| op_a | input | 8 | Signed operand A |
| op_b | input | 8 | Signed operand B |
| acc_out | output | ACC_W (32) | Current saturated accumulator value |

## Verification
The assertions assume that `clr`, `in_valid` and both operands hold known values at every rising edge once reset has been released. They also assume that reset is held low for at least one edge before operation. The bench meets both conditions: it drives every input to a defined value on falling edges from time zero, including while reset is low. It reaches the saturation limits by streaming full-scale products, using a second lane of reduced accumulator width alongside the default 32-bit lane. This keeps the run short while still covering the exact threshold on each side.

// File: rtl/mac_lane_pkg.sv
// Package: shared types for the saturating MAC lane.
// Assumes: nothing; holds only declarations.
package mac_lane_pkg;

    // Outcome of checking a widened sum against the accumulator range.
    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_HIGH = 2'd1,
        SAT_LOW  = 2'd2
    } sat_kind_e;

endpackage

// File: rtl/mac_product_stage.sv
// Module: mac_product_stage
// Multiplies two signed operands and registers the product together with a
// valid flag. When no pair is offered, or on clear/reset, it loads zero and a
// low flag, so the stage downstream sees nothing to add.
// Assumes: operands are two's-complement; clr and in_valid are synchronous.
module mac_product_stage #(
    parameter int OP_W = 8,
    localparam int PROD_W = 2 * OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [PROD_W-1:0] prod_q,
    output logic              prod_vld
);

    logic signed [PROD_W-1:0] mult_c;

    // Full-width signed product of the current pair.
    always_comb begin
        mult_c = $signed(op_a) * $signed(op_b);
    end

    // Capture the product, or zero when the pair is absent or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prod_q   <= '0;
            prod_vld <= 1'b0;
        end else if (in_valid) begin
            prod_q   <= mult_c;
            prod_vld <= 1'b1;
        end else begin
            prod_q   <= '0;
            prod_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/sat_clamp.sv
// Module: sat_clamp
// Classifies a sum that is one bit wider than the accumulator. The two top
// bits disagree exactly when the true value lies outside the signed range;
// the top bit then tells which side.
// Assumes: the sum was formed from two sign-extended signed values.
module sat_clamp #(
    parameter int ACC_W = 32,
    localparam int SUM_W = ACC_W + 1
) (
    input  logic [SUM_W-1:0]     sum_in,
    output mac_lane_pkg::sat_kind_e kind
);

    // Pick the overflow side from the two top bits.
    always_comb begin
        if (sum_in[SUM_W-1] == sum_in[SUM_W-2]) begin
            kind = mac_lane_pkg::SAT_NONE;
        end else if (sum_in[SUM_W-1]) begin
            kind = mac_lane_pkg::SAT_LOW;
        end else begin
            kind = mac_lane_pkg::SAT_HIGH;
        end
    end

endmodule

// File: rtl/mac_acc_stage.sv
// Module: mac_acc_stage
// Accumulator feedback loop: adds a registered, sign-extended product into a
// signed register and clamps to the range limits instead of wrapping.
// Assumes: prod_q is already registered upstream and is zero when prod_vld
// is low; ACC_W is greater than PROD_W.
module mac_acc_stage #(
    parameter int PROD_W = 16,
    parameter int ACC_W  = 32,
    localparam int SUM_W = ACC_W + 1,
    localparam int EXT_W = SUM_W - PROD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              prod_vld,
    input  logic [PROD_W-1:0] prod_q,
    output logic [ACC_W-1:0]  acc_q
);

    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic [SUM_W-1:0]          prod_ext;
    logic [SUM_W-1:0]          acc_ext;
    logic [SUM_W-1:0]          sum_c;
    logic [ACC_W-1:0]          next_c;
    mac_lane_pkg::sat_kind_e   kind_c;

    // Sign-extend both addends to the widened sum width and add them.
    always_comb begin
        prod_ext = {{EXT_W{prod_q[PROD_W-1]}}, prod_q};
        acc_ext  = {acc_q[ACC_W-1], acc_q};
        sum_c    = acc_ext + prod_ext;
    end

    sat_clamp #(
        .ACC_W (ACC_W)
    ) clamp_i (
        .sum_in (sum_c),
        .kind   (kind_c)
    );

    // Replace an out-of-range sum by the bound on its side.
    always_comb begin
        case (kind_c)
            mac_lane_pkg::SAT_HIGH: next_c = ACC_MAX;
            mac_lane_pkg::SAT_LOW:  next_c = ACC_MIN;
            default:                next_c = sum_c[ACC_W-1:0];
        endcase
    end

    // Accumulator register: reset/clear first, then add when a product is present.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (prod_vld) begin
            acc_q <= next_c;
        end
    end

endmodule

// File: rtl/sat_mac_lane.sv
// Module: sat_mac_lane (top)
// One lane of a SIMD multiply-accumulate engine: a registered signed product
// stage followed by a saturating accumulator. Latency from an accepted pair
// to the accumulator is two rising edges.
// Assumes: the enclosing core supplies operands already unpacked from the
// vector word and handles flow control and output-valid timing.
module sat_mac_lane #(
    parameter int OP_W  = 8,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic [ACC_W-1:0] acc_out
);

    localparam int PROD_W = 2 * OP_W;

    logic [PROD_W-1:0] prod_q;
    logic              prod_vld;

    mac_product_stage #(
        .OP_W (OP_W)
    ) prod_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_valid (in_valid),
        .op_a     (op_a),
        .op_b     (op_b),
        .prod_q   (prod_q),
        .prod_vld (prod_vld)
    );

    mac_acc_stage #(
        .PROD_W (PROD_W),
        .ACC_W  (ACC_W)
    ) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .prod_vld (prod_vld),
        .prod_q   (prod_q),
        .acc_q    (acc_out)
    );

endmodule

// File: rtl/sat_mac_lane_chk.sv
// Module: sat_mac_lane_chk
// Property checker bound to sat_mac_lane. Watches the ports and the product
// stage outputs that link the two internal stages.
// Assumes: inputs are known at every edge after reset has been applied.
module sat_mac_lane_chk #(
    parameter int OP_W  = 8,
    parameter int ACC_W = 32,
    localparam int PROD_W = 2 * OP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              in_valid,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic [ACC_W-1:0]  acc_out,
    input logic [PROD_W-1:0] prod_q,
    input logic              prod_vld
);

    localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

    logic past_ok;

    // Marks that the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1: first cycle after reset shows an empty accumulator.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> acc_out == '0);

    // R2, R3: an accepted pair appears as its signed product one edge later.
    a_r2_product_registered: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(in_valid && !clr) |->
            prod_vld && ($signed(prod_q) == ($signed($past(op_a)) * $signed($past(op_b)))));

    // R4: nothing registered means the accumulator holds.
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(clr) && !$past(prod_vld) |-> $stable(acc_out));

    // R5, R7: upper limit is sticky under non-negative products.
    a_r5_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(clr) && $past(prod_vld) && $past(acc_out) == MAXV
            && !$past(prod_q[PROD_W-1]) |-> acc_out == MAXV);

    // R6, R7: lower limit is sticky under negative products.
    a_r6_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(clr) && $past(prod_vld) && $past(acc_out) == MINV
            && $past(prod_q[PROD_W-1]) |-> acc_out == MINV);

    // R5: a non-negative product never makes the value smaller (no wrap).
    a_r5_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(clr) && $past(prod_vld) && !$past(prod_q[PROD_W-1])
            |-> $signed(acc_out) >= $signed($past(acc_out)));

    // R6: a negative product never makes the value larger (no wrap).
    a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(clr) && $past(prod_vld) && $past(prod_q[PROD_W-1])
            |-> $signed(acc_out) <= $signed($past(acc_out)));

    // R8: clear empties both stages at the same edge.
    a_r8_clear_both: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(clr) |-> acc_out == '0 && !prod_vld);

endmodule

bind sat_mac_lane sat_mac_lane_chk #(
    .OP_W  (OP_W),
    .ACC_W (ACC_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .acc_out  (acc_out),
    .prod_q   (prod_q),
    .prod_vld (prod_vld)
);

// File: tb/sat_mac_lane_tb_top.sv
`timescale 1ns/1ps
module sat_mac_lane_tb_top;

    localparam int SW = 20;  // reduced-width lane for quick saturation (R9)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        vld = 1'b0;
    logic [7:0]  a = '0;
    logic [7:0]  b = '0;
    logic [31:0] acc;

    logic          s_clr = 1'b0;
    logic          s_vld = 1'b0;
    logic [7:0]    s_a = '0;
    logic [7:0]    s_b = '0;
    logic [SW-1:0] s_acc;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sat_mac_lane dut_i (
        .clk (clk), .rst_n (rst_n), .clr (clr), .in_valid (vld),
        .op_a (a), .op_b (b), .acc_out (acc)
    );

    sat_mac_lane #(.ACC_W (SW)) sat_i (
        .clk (clk), .rst_n (rst_n), .clr (s_clr), .in_valid (s_vld),
        .op_a (s_a), .op_b (s_b), .acc_out (s_acc)
    );

    typedef struct packed {
        logic        c;
        logic        v;
        logic [7:0]  pa;
        logic [7:0]  pb;
        logic [31:0] exp;
    } vec_t;

    // Each row is driven for one cycle; exp is acc_out after that edge,
    // so it reflects products of rows up to the previous one (R2).
    localparam vec_t VECS [0:12] = '{
        '{1'b0, 1'b1, 8'd3,   8'd4,   32'd0},      // R2 not yet visible
        '{1'b0, 1'b1, 8'hFE,  8'd5,   32'd12},     // R2 3*4
        '{1'b0, 1'b0, 8'h55,  8'h66,  32'd2},      // R3 -2*5
        '{1'b0, 1'b1, 8'h80,  8'h80,  32'd2},      // R4 idle row ignored
        '{1'b0, 1'b1, 8'h80,  8'h7F,  32'd16386},  // R3 +16384
        '{1'b0, 1'b0, 8'h7F,  8'h7F,  32'd130},    // R3 -16256
        '{1'b0, 1'b0, 8'h12,  8'h34,  32'd130},    // R4 hold
        '{1'b1, 1'b1, 8'd7,   8'd7,   32'd0},      // R8 clear
        '{1'b0, 1'b1, 8'd1,   8'd1,   32'd0},      // R8 cleared pair gone
        '{1'b0, 1'b0, 8'd0,   8'd0,   32'd1},      // R2 1*1
        '{1'b0, 1'b1, 8'd127, 8'd127, 32'd1},
        '{1'b1, 1'b0, 8'd0,   8'd0,   32'd0},      // R8 clear beats pending
        '{1'b0, 1'b0, 8'd0,   8'd0,   32'd0}       // R8 pending product lost
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: acc_out=%h expected %h", req, act, exp);
        end
    endtask

    // Stream n identical pairs into the default lane, then let them retire.
    task automatic run_main(input int n, input logic [7:0] pa, input logic [7:0] pb);
        @(negedge clk);
        vld = 1'b1; a = pa; b = pb;
        repeat (n) @(negedge clk);
        vld = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    // Same for the reduced-width lane.
    task automatic run_sat(input int n, input logic [7:0] pa, input logic [7:0] pb);
        @(negedge clk);
        s_vld = 1'b1; s_a = pa; s_b = pb;
        repeat (n) @(negedge clk);
        s_vld = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic clear_sat();
        @(negedge clk);
        s_clr = 1'b1;
        @(negedge clk);
        s_clr = 1'b0;
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: pairs offered during reset must not accumulate.
        vld = 1'b1; a = 8'd5; b = 8'd5;
        repeat (3) @(posedge clk);
        #1;
        check("R1 during reset", acc, 32'd0);
        @(negedge clk);
        vld = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", acc, 32'd0);
        @(posedge clk); #1;
        check("R1 no stale product", acc, 32'd0);

        // Table walk: R2, R3, R4, R8.
        for (int i = 0; i <= 12; i++) begin
            @(negedge clk);
            clr = VECS[i].c; vld = VECS[i].v; a = VECS[i].pa; b = VECS[i].pb;
            @(posedge clk); #1;
            check($sformatf("R2/R3/R4/R8 row %0d", i), acc, VECS[i].exp);
        end
        @(negedge clk);
        clr = 1'b0; vld = 1'b0;

        // R5, R7 at full width: 131073 * 16384 exceeds 2^31-1.
        run_main(131073, 8'h80, 8'h80);
        check("R5 full-width upper clamp", acc, 32'h7FFFFFFF);
        run_main(1, 8'h80, 8'h7F);
        check("R7 off upper limit", acc, 32'h7FFFC07F);

        // R9, R5 at reduced width: limit 0x7FFFF.
        run_sat(31, 8'h80, 8'h80);
        check("R5 just below limit", {12'b0, s_acc}, 32'h0007C000);
        run_sat(1, 8'h80, 8'h80);
        check("R9 R5 exact crossing clamps", {12'b0, s_acc}, 32'h0007FFFF);
        run_sat(4, 8'h7F, 8'h7F);
        check("R7 upper sticky", {12'b0, s_acc}, 32'h0007FFFF);

        // R9, R6: lower limit 0x80000.
        clear_sat();
        run_sat(32, 8'h80, 8'h7F);
        check("R6 above lower limit", {12'b0, s_acc}, 32'h00081000);
        run_sat(1, 8'h80, 8'h7F);
        check("R9 R6 crossing clamps", {12'b0, s_acc}, 32'h00080000);
        run_sat(5, 8'h81, 8'h7F);
        check("R7 lower sticky", {12'b0, s_acc}, 32'h00080000);
        run_sat(1, 8'h80, 8'h80);
        check("R7 off lower limit", {12'b0, s_acc}, 32'h00084000);

        // R8 on a saturated value.
        clear_sat();
        @(posedge clk); #1;
        check("R8 clear from limit", {12'b0, s_acc}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule